// File: doc/BRIEF.md
# Two-Bit Pseudo-Random Source

This block is a free-running pseudo-random bit source built on an 8-stage linear feedback shift register. On every rising clock edge a single new bit, formed by an XNOR over four register stages, enters the register at its low end. The two lowest stages drive a 2-bit output word. Each edge adds only one new bit, so the whole 2-bit word is new only on every second edge.

A phase flag toggles on each edge alongside the register. A consumer that reads the word only on cycles where the flag is low receives consecutive, non-overlapping bit pairs from the sequence. An active-low asynchronous reset loads the all-zero seed. Because the feedback is XNOR, all zeros is a normal state and not a lock-up, so every run after reset produces the same sequence.

Top module: `prbs2_source`

## Requirements
- R1: On each rising clock edge outside reset, exactly one new bit enters the register and appears on `rnd[0]`. The bit that was on `rnd[0]` before the edge moves to `rnd[1]`.
- R2: Number the stages 1 to 8, with stage 1 holding the newest bit (`rnd[0]`). The new bit is the inverted XOR (XNOR) of stages 8, 6, 5 and 4 as they were before the edge.
- R3: While `rst_n` is low, the register holds all zeros, so `rnd` = 2'b00, and `fresh` = 0. Both take effect at once, without waiting for a clock edge.
- R4: The register never holds the all-ones value. This is the only excluded state.
- R5: The sequence has a period of exactly 255 edges. The window of the last 8 bits seen on `rnd[0]` repeats after 255 edges, and never after fewer edges.
- R6: `fresh` is 0 out of reset and inverts on every rising clock edge.
- R7: Consider the cycles where `fresh` is 0 after at least two edges since reset. On these cycles `rnd` holds the two bits produced since the previous such cycle. The pairs read on these cycles, taken in order, rebuild the bit stream with no bit repeated or skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads the all-zero seed |
| rnd | output | 2 | `rnd[0]` is the newest bit, `rnd[1]` the bit before it |
| fresh | output | 1 | Phase flag; when low, the pair on `rnd` is entirely new |

## Verification
Each new bit is due on `rnd[0]` one rising edge after the cycle that produced it. It then moves to `rnd[1]` one edge later, and `fresh` inverts on the same edge. The bench drives inputs and samples outputs on falling edges, so every comparison falls half a period after the edge that set the value. The asynchronous reset has no clock latency. The bench asserts it shortly after a rising edge and checks the outputs 1 ns later, well before the next edge. The period and all-ones checks use the last eight observed values of `rnd[0]`, which equal the register contents.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int PRBS_W = 8;
    // stages 8,6,5,4 (1-based) -> bit indices 7,5,4,3
    localparam logic [PRBS_W-1:0] PRBS_TAPS = 8'b1011_1000;

    typedef struct packed {
        logic [1:0] pair;
        logic       fresh;
    } prbs_word_t;

    function automatic logic xnor_feedback(input logic [PRBS_W-1:0] st,
                                           input logic [PRBS_W-1:0] taps);
        return ~(^(st & taps));
    endfunction

endpackage

// File: rtl/prbs_shift_reg.sv
module prbs_shift_reg #(
    parameter int                  W    = 8,
    parameter logic [W-1:0]        TAPS = 8'b1011_1000
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic fb;

    always_comb fb = ~(^(state & TAPS));

    // stage 0 takes the feedback, each later stage takes its lower neighbour
    for (genvar g = 0; g < W; g++) begin : g_stage
        logic d;
        if (g == 0) begin : g_head
            always_comb d = fb;
        end else begin : g_body
            always_comb d = state[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state[g] <= 1'b0;
            else        state[g] <= d;
        end
    end
endmodule

// File: rtl/prbs_phase.sv
module prbs_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end
endmodule

// File: rtl/prbs2_source.sv
module prbs2_source
    import prbs_pkg::*;
#(
    parameter int               W    = PRBS_W,
    parameter logic [W-1:0]     TAPS = PRBS_TAPS
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] rnd,
    output logic       fresh
);
    localparam int PAIR_LSB = 0;

    logic [W-1:0] state;
    logic         phase;
    prbs_word_t   word;

    prbs_shift_reg #(.W(W), .TAPS(TAPS)) u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state)
    );

    prbs_phase u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    always_comb begin
        word.pair  = state[PAIR_LSB+1:PAIR_LSB];
        word.fresh = phase;
    end

    assign rnd   = word.pair;
    assign fresh = word.fresh;
endmodule

// File: rtl/prbs2_source_chk.sv
module prbs2_source_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   rnd,
    input logic         fresh,
    input logic [W-1:0] state
);
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R1
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> rnd[1] == $past(rnd[0]));

    // R2
    feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> rnd[0] == ~($past(state[7]) ^ $past(state[5]) ^ $past(state[4]) ^ $past(state[3])));

    // R4
    no_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != {W{1'b1}});

    // R6
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> fresh != $past(fresh));
endmodule

bind prbs2_source prbs2_source_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd   (rnd),
    .fresh (fresh),
    .state (state)
);

// File: tb/prbs2_source_test.sv
module prbs2_source_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rnd;
    logic       fresh;

    int checks = 0;
    int errors = 0;

    localparam int NOBS = 600;
    logic obs [NOBS];

    prbs2_source uut (.clk(clk), .rst_n(rst_n), .rnd(rnd), .fresh(fresh));

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 rnd in reset", rnd == 2'b00, rnd, 0);
        check("R3/R6 fresh in reset", fresh == 1'b0, fresh, 0);
        rst_n = 1'b1;
    endtask

    // model from R2, compared each cycle; also R1, R6, R7; stores the stream
    task automatic t_stream();
        logic [7:0] m = 8'h00;
        logic       prev0 = 1'b0;
        logic       expf = 1'b0;
        int bad1 = 0, bad2 = 0, bad6 = 0, bad7 = 0;
        logic [1:0] pr;
        do_reset();
        for (int i = 0; i < NOBS; i++) begin
            @(negedge clk);
            m = {m[6:0], ~(m[7] ^ m[5] ^ m[4] ^ m[3])};
            expf = ~expf;
            obs[i] = rnd[0];
            if (rnd[1] != prev0) bad1++;
            if (rnd != m[1:0]) bad2++;
            if (fresh != expf) bad6++;
            if (i >= 1 && fresh == 1'b0) begin
                pr = {obs[i-1], obs[i]};
                if (rnd != pr) bad7++;
            end
            prev0 = rnd[0];
        end
        check("R1 shift order", bad1 == 0, bad1, 0);
        check("R2 xnor feedback", bad2 == 0, bad2, 0);
        check("R6 phase toggle", bad6 == 0, bad6, 0);
        check("R7 fresh pairs", bad7 == 0, bad7, 0);
    endtask

    function automatic logic [7:0] win(input int i);
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[k] = obs[i-k];
        return w;
    endfunction

    task automatic t_period_and_lockout();
        int ones = 0, rep = 0, early = 0;
        for (int i = 7; i < NOBS; i++)
            if (win(i) == 8'hFF) ones++;
        check("R4 no all-ones window", ones == 0, ones, 0);
        for (int i = 7; i + 255 < NOBS; i++)
            if (win(i) != win(i + 255)) rep++;
        check("R5 repeat after 255", rep == 0, rep, 0);
        for (int k = 1; k < 255; k++)
            if (win(7) == win(7 + k)) early++;
        check("R5 no earlier repeat", early == 0, early, 0);
        check("R2 first bits after seed", win(7) == 8'hFF ? 1'b0 : 1'b1, win(7), 0);
    endtask

    task automatic t_async_reset();
        repeat (5) @(negedge clk);
        @(posedge clk);
        #2 rst_n = 1'b0;
        #1;
        check("R3 async rnd", rnd == 2'b00, rnd, 0);
        check("R3 async fresh", fresh == 1'b0, fresh, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3/R2 first bit after reset", rnd == 2'b01, rnd, 1);
        check("R6 fresh after one edge", fresh == 1'b1, fresh, 1);
        @(negedge clk);
        check("R1 second edge", rnd == 2'b11, rnd, 3);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_stream();
        t_period_and_lockout();
        t_async_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule